// File: doc/BRIEF.md
# ISA I/O Window Decoder

This block sits between a 16-bit ISA I/O address bus and four programmable logic slices on one add-in module. It watches the address lines, the address-enable line and the two I/O strobes. It then decides whether the current cycle targets the module, which slice it targets, and which of that slice's sixteen byte ports is addressed. The module answers only inside a window picked by a 6-bit base-address switch that is compared with address bits 9..4. A fixed upper nibble of hex A is also required. The four slices sit 1 KB apart, and address bits 11..10 pick the slice.

For each slice the decoder itself answers reads of a two-byte circuit identifier, taken from constant inputs. The slice logic behind it serves every other port. The decoder also drives an activity LED. The LED lights during any read or write that hits the window and stays lit for a programmable number of clocks after the last hit, so that short bus cycles can be seen.

All decode outputs are combinational from the bus inputs, so a select is valid within the same bus cycle. Only the LED stretch counter is registered. There is no streaming data path, so no valid/ready handshake applies. Every pin is a plain level signal.

Top module: `io_window_decoder`

## Requirements
- R1: The module is selected only when address bits 9..4 equal `base_sw[5:0]`. Any single differing bit in that field deselects it.
- R2: The module is selected only when address bits 15..12 equal hex A. Any other value deselects it.
- R3: While `aen` is high, no slice select, `rd_drive` or `id_claim` is asserted. A cycle with `aen` high does not light the activity LED.
- R4: On an address match, exactly one bit of `slice_sel` is high, and the strobes are not needed for this. Bit n is high when address bits 11..10 equal n, so offsets A000h, A400h, A800h and AC00h from the base select slices 0, 1, 2 and 3.
- R5: `port_ofs` equals address bits 3..0 while the module is selected, and is zero otherwise.
- R6: `rd_drive` is high only when the module is selected and `ior_n` is low. A write strobe (`iow_n` low) alone never raises it.
- R7: A selected read at offset Eh returns that slice's byte from `id_letter` (slice n uses bits 8n+7..8n). A read at offset Fh returns that slice's byte from `id_number`. Both raise `id_claim`. Any other offset, and any write, leaves `id_claim` low and `rd_data` zero.
- R8: `act_led` is high in every clock in which the module is selected and either strobe is low. An address match with both strobes high does not light it.
- R9: After the last clock of a hit with a strobe, `act_led` stays high for exactly `stretch_len` further clocks. A new hit reloads the count. A `stretch_len` of zero gives no stretch.
- R10: While `rst_n` is low and no cycle hits the window, `act_led` is low. After reset no stretch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the LED stretch counter |
| rst_n | input | 1 | Active-low synchronous reset |
| sa | input | 16 | I/O address bus |
| aen | input | 1 | Address enable; high during DMA cycles |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| base_sw | input | 6 | Base-address switch, compared with address bits 9..4 |
| stretch_len | input | 8 | LED hold time in clocks after the last hit |
| id_letter | input | 32 | Per-slice identifier type letter, one byte per slice |
| id_number | input | 32 | Per-slice identifier circuit number, one byte per slice |
| slice_sel | output | 4 | One-hot slice select |
| port_ofs | output | 4 | Port offset inside the selected slice |
| rd_drive | output | 1 | Data-bus drive enable for a selected read |
| rd_data | output | 8 | Identifier byte returned by the decoder |
| id_claim | output | 1 | High when the decoder itself answers the read |
| act_led | output | 1 | Activity indicator drive |

## Verification
The bench builds the decoder with a 4-bit stretch counter instead of the 8-bit default. This makes a `stretch_len` of fifteen the largest value, so the full-count hold and the zero-length case both fit into short runs. The address layout keeps its default widths. Each field boundary (the upper nibble, the six switch bits, the slice pair and the offset) is therefore exercised at its real bit position. Base values of 00h, 11h and 3Fh put both all-zero and all-one switch patterns against the comparator.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  // Kind of bus access seen in the current clock.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Offsets inside a slice window that the decoder answers itself.
  localparam logic [3:0] ID_TYPE_OFS = 4'hE;
  localparam logic [3:0] ID_NUM_OFS  = 4'hF;

  function automatic acc_kind_e classify(input logic rd_n, input logic wr_n);
    if (!rd_n)      return ACC_READ;
    else if (!wr_n) return ACC_WRITE;
    else            return ACC_IDLE;
  endfunction

endpackage

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 4,
  parameter int BASE_W  = 6,
  parameter int SLICE_W = 2,
  parameter logic [ADDR_W-OFS_W-BASE_W-SLICE_W-1:0] TOP_VAL = 'hA
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               aen,
  input  logic [BASE_W-1:0]  base_sw,
  output logic               hit,
  output logic [SLICE_W-1:0] slice_idx,
  output logic [OFS_W-1:0]   ofs
);
  localparam int BASE_LO = OFS_W;
  localparam int BASE_HI = OFS_W + BASE_W - 1;
  localparam int SL_LO   = BASE_HI + 1;
  localparam int SL_HI   = SL_LO + SLICE_W - 1;
  localparam int TOP_LO  = SL_HI + 1;

  logic base_eq;
  logic top_eq;

  assign base_eq   = (addr[BASE_HI:BASE_LO] == base_sw);
  assign top_eq    = (addr[ADDR_W-1:TOP_LO] == TOP_VAL);
  assign hit       = !aen && base_eq && top_eq;
  assign slice_idx = addr[SL_HI:SL_LO];
  assign ofs       = addr[OFS_W-1:0];
endmodule

// File: rtl/iowin_id_mux.sv
module iowin_id_mux
  import iowin_pkg::*;
#(
  parameter int SLICE_W = 2,
  parameter int OFS_W   = 4,
  parameter int DATA_W  = 8
) (
  input  logic                            rd_en,
  input  logic [SLICE_W-1:0]              slice_idx,
  input  logic [OFS_W-1:0]                ofs,
  input  logic [(1<<SLICE_W)*DATA_W-1:0]  letters,
  input  logic [(1<<SLICE_W)*DATA_W-1:0]  numbers,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            claim
);
  localparam int SLICES = 1 << SLICE_W;

  logic [DATA_W-1:0] let_a [SLICES];
  logic [DATA_W-1:0] num_a [SLICES];

  for (genvar g = 0; g < SLICES; g++) begin : g_unpack
    assign let_a[g] = letters[g*DATA_W +: DATA_W];
    assign num_a[g] = numbers[g*DATA_W +: DATA_W];
  end

  logic is_type;
  logic is_num;

  assign is_type = (ofs == OFS_W'(ID_TYPE_OFS));
  assign is_num  = (ofs == OFS_W'(ID_NUM_OFS));
  assign claim   = rd_en && (is_type || is_num);

  always_comb begin
    rd_data = '0;
    if (rd_en && is_type)     rd_data = let_a[slice_idx];
    else if (rd_en && is_num) rd_data = num_a[slice_idx];
  end
endmodule

// File: rtl/iowin_activity.sv
module iowin_activity #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strike,
  input  logic [CNT_W-1:0] hold_len,
  output logic             led
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain_q <= '0;
    else if (strike)         remain_q <= hold_len;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign led = strike || (remain_q != '0);
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 4,
  parameter int BASE_W  = 6,
  parameter int SLICE_W = 2,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter logic [ADDR_W-OFS_W-BASE_W-SLICE_W-1:0] TOP_VAL = 'hA
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              sa,
  input  logic                           aen,
  input  logic                           ior_n,
  input  logic                           iow_n,
  input  logic [BASE_W-1:0]              base_sw,
  input  logic [CNT_W-1:0]               stretch_len,
  input  logic [(1<<SLICE_W)*DATA_W-1:0] id_letter,
  input  logic [(1<<SLICE_W)*DATA_W-1:0] id_number,
  output logic [(1<<SLICE_W)-1:0]        slice_sel,
  output logic [OFS_W-1:0]               port_ofs,
  output logic                           rd_drive,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           id_claim,
  output logic                           act_led
);
  localparam int SLICES = 1 << SLICE_W;

  logic               hit;
  logic [SLICE_W-1:0] slice_idx;
  logic [OFS_W-1:0]   ofs;
  acc_kind_e          acc;

  iowin_match #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE_W(BASE_W),
    .SLICE_W(SLICE_W), .TOP_VAL(TOP_VAL)
  ) u_match (
    .addr(sa), .aen(aen), .base_sw(base_sw),
    .hit(hit), .slice_idx(slice_idx), .ofs(ofs)
  );

  assign acc = classify(ior_n, iow_n);

  for (genvar g = 0; g < SLICES; g++) begin : g_sel
    assign slice_sel[g] = hit && (slice_idx == SLICE_W'(g));
  end

  assign port_ofs = hit ? ofs : '0;
  assign rd_drive = hit && (acc == ACC_READ);

  iowin_id_mux #(
    .SLICE_W(SLICE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_id (
    .rd_en(rd_drive), .slice_idx(slice_idx), .ofs(ofs),
    .letters(id_letter), .numbers(id_number),
    .rd_data(rd_data), .claim(id_claim)
  );

  iowin_activity #(.CNT_W(CNT_W)) u_act (
    .clk(clk), .rst_n(rst_n),
    .strike(hit && (acc != ACC_IDLE)),
    .hold_len(stretch_len),
    .led(act_led)
  );
endmodule

// File: rtl/iowin_checker.sv
module iowin_checker #(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 4,
  parameter int BASE_W  = 6,
  parameter int SLICE_W = 2,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              sa,
  input logic                           aen,
  input logic                           ior_n,
  input logic                           iow_n,
  input logic [BASE_W-1:0]              base_sw,
  input logic [CNT_W-1:0]               stretch_len,
  input logic [(1<<SLICE_W)*DATA_W-1:0] id_letter,
  input logic [(1<<SLICE_W)*DATA_W-1:0] id_number,
  input logic [(1<<SLICE_W)-1:0]        slice_sel,
  input logic [OFS_W-1:0]               port_ofs,
  input logic                           rd_drive,
  input logic [DATA_W-1:0]              rd_data,
  input logic                           id_claim,
  input logic                           act_led
);
  logic strobe_hit;
  assign strobe_hit = (|slice_sel) && (!ior_n || !iow_n);

  a_r3_aen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (slice_sel == '0 && !rd_drive && !id_claim));

  a_r4_one_slice: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slice_sel));

  a_r5_ofs_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_sel == '0) |-> (port_ofs == '0));

  a_r6_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (!ior_n && (|slice_sel)));

  a_r7_claim_on_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    id_claim |-> (rd_drive && (&port_ofs[OFS_W-1:1])));

  a_r8_hit_lights: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_hit |-> act_led);

  a_r9_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_hit && stretch_len != '0) |=> act_led);
endmodule

bind io_window_decoder iowin_checker #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE_W(BASE_W),
  .SLICE_W(SLICE_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_io_window_decoder.sv
module sim_io_window_decoder;
  localparam int CNT_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sa = '0;
  logic        aen = 1'b0;
  logic        ior_n = 1'b1;
  logic        iow_n = 1'b1;
  logic [5:0]  base_sw = 6'h11;
  logic [CNT_W-1:0] stretch_len = '0;
  logic [31:0] id_letter = {8'h66, 8'h74, 8'h67, 8'h6E};
  logic [31:0] id_number = {8'd32, 8'd255, 8'd1, 8'd0};
  logic [3:0]  slice_sel;
  logic [3:0]  port_ofs;
  logic        rd_drive;
  logic [7:0]  rd_data;
  logic        id_claim;
  logic        act_led;

  always #5 clk = ~clk;

  io_window_decoder #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .ior_n(ior_n),
    .iow_n(iow_n), .base_sw(base_sw), .stretch_len(stretch_len),
    .id_letter(id_letter), .id_number(id_number),
    .slice_sel(slice_sel), .port_ofs(port_ofs), .rd_drive(rd_drive),
    .rd_data(rd_data), .id_claim(id_claim), .act_led(act_led)
  );

  int    vectors = 0;
  int    fails = 0;
  int    ref_cnt = 0;
  bit    done = 0;
  string cur_req = "R10";

  function automatic bit ref_hit();
    return !aen && sa[15:12] == 4'hA && sa[9:4] == base_sw;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ref_cnt = 0;
    else if (ref_hit() && (!ior_n || !iow_n)) ref_cnt = int'(stretch_len);
    else if (ref_cnt > 0) ref_cnt = ref_cnt - 1;
  end

  task automatic cmp(string what, int got, int exp);
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit h, rd, cl;
    int idx, e_sel, e_dat;
    h   = ref_hit();
    idx = int'(sa[11:10]);
    rd  = h && !ior_n;
    cl  = rd && sa[3:0] >= 4'hE;
    e_sel = h ? (1 << idx) : 0;
    e_dat = cl ? (sa[0] ? int'(id_number[idx*8 +: 8]) : int'(id_letter[idx*8 +: 8])) : 0;
    vectors++;
    cmp("slice_sel", int'(slice_sel), e_sel);
    cmp("port_ofs", int'(port_ofs), h ? int'(sa[3:0]) : 0);
    cmp("rd_drive", int'(rd_drive), int'(rd));
    cmp("id_claim", int'(id_claim), int'(cl));
    cmp("rd_data", int'(rd_data), e_dat);
    cmp("act_led", int'(act_led), int'((h && (!ior_n || !iow_n)) || ref_cnt != 0));
  end

  task automatic step(input logic [15:0] a, input logic e, input logic r, input logic w);
    @(posedge clk); #1;
    sa = a; aen = e; ior_n = r; iow_n = w;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(16'h0000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL %s watchdog: got timeout expected completion", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    // R10: reset keeps the indicator dark
    cur_req = "R10";
    idle(4);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(2);

    // R1: switch match on bits 9..4, each bit flipped
    cur_req = "R1";
    step(16'hA110, 0, 0, 1);
    for (int b = 0; b < 6; b++) step(16'hA110 ^ (16'h0010 << b), 0, 0, 1);
    base_sw = 6'h3F;
    step(16'hA3F0, 0, 1, 0);
    step(16'hA3E0, 0, 1, 0);
    base_sw = 6'h00;
    step(16'hA00E, 0, 0, 1);
    step(16'hA01E, 0, 0, 1);
    base_sw = 6'h11;

    // R2: upper nibble must be hex A
    cur_req = "R2";
    step(16'hB110, 0, 0, 1);
    step(16'h2110, 0, 0, 1);
    step(16'h0110, 0, 1, 0);
    step(16'hE110, 0, 0, 1);
    idle(2);

    // R3: AEN inhibits everything
    cur_req = "R3";
    stretch_len = 4'd3;
    step(16'hA11E, 1, 0, 1);
    step(16'hA51F, 1, 1, 0);
    idle(2);

    // R4: slice chosen by bits 11..10, no strobe needed
    cur_req = "R4";
    step(16'hA110, 0, 1, 1);
    step(16'hA513, 0, 1, 1);
    step(16'hA917, 0, 1, 1);
    step(16'hAD1C, 0, 1, 1);

    // R5: offset passthrough in slice 2
    cur_req = "R5";
    for (int o = 0; o < 16; o++) step(16'hA910 | 16'(o), 0, 1, 0);
    idle(5);

    // R6: writes never raise the drive enable
    cur_req = "R6";
    step(16'hA11E, 0, 1, 0);
    step(16'hA51F, 0, 1, 0);
    step(16'hA515, 0, 0, 1);

    // R7: identifier readback for every slice
    cur_req = "R7";
    for (int s = 0; s < 4; s++) begin
      step(16'hA11E | 16'(s << 10), 0, 0, 1);
      step(16'hA11F | 16'(s << 10), 0, 0, 1);
      step(16'hA11D | 16'(s << 10), 0, 0, 1);
    end
    base_sw = 6'h3F;
    step(16'hAFFF, 0, 0, 1);
    step(16'hAFFE, 0, 0, 0);
    base_sw = 6'h11;
    idle(5);

    // R8: lit during hit cycles only with a strobe
    cur_req = "R8";
    stretch_len = 4'd0;
    step(16'hA110, 0, 1, 1);
    step(16'hA110, 0, 0, 1);
    step(16'hA110, 0, 1, 1);
    step(16'hA510, 0, 1, 0);
    idle(2);

    // R9: stretch, retrigger and full count
    cur_req = "R9";
    stretch_len = 4'd5;
    step(16'hA112, 0, 1, 0);
    idle(8);
    step(16'hA112, 0, 0, 1);
    idle(3);
    step(16'hA912, 0, 1, 0);
    idle(8);
    stretch_len = 4'd15;
    step(16'hAD12, 0, 0, 1);
    step(16'hAD12, 0, 0, 1);
    idle(18);

    // R10: reset mid-stretch clears the pending hold
    cur_req = "R10";
    step(16'hA112, 0, 1, 0);
    idle(2);
    @(posedge clk); #1; rst_n = 1'b0;
    idle(2);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule